// File: doc/BRIEF.md
# Dual-Line Interrupt Cause Controller

This block gathers up to 32 hardware event pulses into one sticky cause register. A single unmask register selects which events may raise an interrupt. The unmasked events then drive two separate level-sensitive interrupt lines, split by bit group. Cause bits 24 to 27 form the legacy INTx group, and the unmasked ones drive `intx_irq`. Every other unmasked bit drives `err_irq`. This second line also carries notices that are not errors, such as power-management events.

Software services each line on its own. It reads the cause register, which has no read side effects. It then writes ones to the bits it has handled, which clears only those bits. A handler for one line therefore never disturbs events pending on the other line. Each line stays asserted while any of its own unmasked bits remains set.

Top module: `dual_irq_cause`

## Requirements
- R1: After a synchronous active-high reset, the cause register and the unmask register read as zero, both interrupt lines are low and `bus_rdata` is zero.
- R2: A one-cycle pulse on `evt_pulse[i]` sets cause bit i at the next clock edge, and the bit stays set until software clears it.
- R3: Reading the cause register (offset 0x0) leaves every cause bit unchanged.
- R4: Writing the cause register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R5: When an event pulse and a write-one-to-clear hit the same cause bit in the same cycle, the bit ends up set.
- R6: The cause register is at offset 0x0 and the unmask register at offset 0x4. The unmask register is fully read/write. Read data appears on `bus_rdata` one clock after the cycle in which `bus_rd` is sampled high.
- R7: `intx_irq` is high exactly when some cause bit in 24..27 is set and unmasked. It follows the register state with one clock of delay.
- R8: `err_irq` is high exactly when some cause bit outside 24..27 is set and unmasked. It follows the register state with one clock of delay.
- R9: A masked event still sets its cause bit but raises no line. Unmasking a pending bit later raises its line.
- R10: After a partial clear, each line stays high while any of its own unmasked bits is still pending. Clearing one line's bits does not affect the other line.
- R11: A read of any offset other than 0x0 or 0x4 returns zero, and a write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | 32 | One-cycle hardware event pulses, one per cause bit |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one clock after the read strobe |
| intx_irq | output | 1 | Level interrupt for the INTx event group |
| err_irq | output | 1 | Level interrupt for all other events |

## Verification
A hardware event and a software write-one-to-clear can land on the same cause bit in one cycle. The bench provokes this by driving the event pulse and the clearing write in the same cycle. It then reads the cause register back and expects the bit to still be set. A second clear, sent with no event pulse, must then empty the register. The bench also runs a partial clear while both lines are high, and checks that only the serviced line falls.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_MASK  = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode #(
  parameter int DW       = 32,
  parameter int AW       = 4,
  parameter int CAUSE_OFS = 0,
  parameter int MASK_OFS  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] cause_i,
  input  logic [DW-1:0] mask_i,
  output logic [DW-1:0] w1c_o,
  output logic          mask_we_o,
  output logic [DW-1:0] mask_wdata_o,
  output logic [DW-1:0] rdata_o
);
  import irqc_pkg::*;

  localparam logic [AW-1:0] CAUSE_A = AW'(CAUSE_OFS);
  localparam logic [AW-1:0] MASK_A  = AW'(MASK_OFS);

  reg_sel_e sel;

  always_comb begin
    if (addr_i == CAUSE_A)     sel = SEL_CAUSE;
    else if (addr_i == MASK_A) sel = SEL_MASK;
    else                       sel = SEL_NONE;
  end

  // writes: cause takes write-one-to-clear, mask takes a plain load
  always_comb begin
    w1c_o        = '0;
    mask_we_o    = 1'b0;
    mask_wdata_o = wdata_i;
    if (wr_i) begin
      case (sel)
        SEL_CAUSE: w1c_o     = wdata_i;
        SEL_MASK:  mask_we_o = 1'b1;
        default:   ;
      endcase
    end
  end

  // registered read path, unmapped offsets return zero
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      case (sel)
        SEL_CAUSE: rdata_o <= cause_i;
        SEL_MASK:  rdata_o <= mask_i;
        default:   rdata_o <= '0;
      endcase
    end
  end

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i != CAUSE_A && addr_i != MASK_A) |=> (rdata_o == '0)); // R11

endmodule

// File: rtl/irqc_cause.sv
module irqc_cause #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] evt_i,
  input  logic [DW-1:0] w1c_i,
  output logic [DW-1:0] cause_o
);

  logic [DW-1:0] cause_q;

  // per bit: event set has priority over software clear
  for (genvar b = 0; b < DW; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           cause_q[b] <= 1'b0;
      else if (evt_i[b]) cause_q[b] <= 1'b1;
      else if (w1c_i[b]) cause_q[b] <= 1'b0;
    end
  end

  assign cause_o = cause_q;

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i))); // R2

  AST_CLEAR_HITS: assert property (@(posedge clk) disable iff (rst)
    (|(w1c_i & ~evt_i)) |=> ((cause_q & $past(w1c_i & ~evt_i)) == '0)); // R4

  AST_NO_STRAY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(cause_q) & ~$past(w1c_i) & ~cause_q) == '0)); // R3

endmodule

// File: rtl/irqc_mask.sv
module irqc_mask #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_o
);

  always_ff @(posedge clk) begin
    if (rst)       mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mask_o)); // R6

endmodule

// File: rtl/irqc_lines.sv
module irqc_lines #(
  parameter int DW      = 32,
  parameter int INTX_LO = 24,
  parameter int INTX_N  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cause_i,
  input  logic [DW-1:0] mask_i,
  output logic          intx_o,
  output logic          err_o
);

  localparam logic [DW-1:0] GRP =
    {{(DW-INTX_N){1'b0}}, {INTX_N{1'b1}}} << INTX_LO;

  logic [DW-1:0] live;
  assign live = cause_i & mask_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      intx_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      intx_o <= |(live & GRP);
      err_o  <= |(live & ~GRP);
    end
  end

  AST_INTX_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (intx_o == |($past(cause_i) & $past(mask_i) & GRP))); // R7

  AST_ERR_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_o == |($past(cause_i) & $past(mask_i) & ~GRP))); // R8

endmodule

// File: rtl/dual_irq_cause.sv
module dual_irq_cause #(
  parameter int DW        = 32,
  parameter int AW        = 4,
  parameter int CAUSE_OFS = 0,
  parameter int MASK_OFS  = 4,
  parameter int INTX_LO   = 24,
  parameter int INTX_N    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] evt_pulse,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          intx_irq,
  output logic          err_irq
);

  logic [DW-1:0] cause, mask, w1c, mask_wd;
  logic          mask_we;

  irqc_decode #(.DW(DW), .AW(AW), .CAUSE_OFS(CAUSE_OFS), .MASK_OFS(MASK_OFS)) u_dec (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .wr_i(bus_wr), .rd_i(bus_rd),
    .wdata_i(bus_wdata), .cause_i(cause), .mask_i(mask), .w1c_o(w1c),
    .mask_we_o(mask_we), .mask_wdata_o(mask_wd), .rdata_o(bus_rdata)
  );

  irqc_cause #(.DW(DW)) u_cause (
    .clk(clk), .rst(rst), .evt_i(evt_pulse), .w1c_i(w1c), .cause_o(cause)
  );

  irqc_mask #(.DW(DW)) u_mask (
    .clk(clk), .rst(rst), .we_i(mask_we), .wdata_i(mask_wd), .mask_o(mask)
  );

  irqc_lines #(.DW(DW), .INTX_LO(INTX_LO), .INTX_N(INTX_N)) u_lines (
    .clk(clk), .rst(rst), .cause_i(cause), .mask_i(mask),
    .intx_o(intx_irq), .err_o(err_irq)
  );

endmodule

// File: tb/dual_irq_cause_bench.sv
module dual_irq_cause_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt_pulse = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        intx_irq, err_irq;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  always #2 clk = ~clk;

  dual_irq_cause u_dual_irq_cause (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .intx_irq(intx_irq), .err_irq(err_irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  // driver: issue read, push expectation for the monitor
  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    tick();
  endtask

  task automatic pulse(input logic [31:0] v);
    evt_pulse = v;
    tick();
    evt_pulse = '0;
  endtask

  // monitor: read data is valid at the negedge after the sampling edge
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: unexpected read data %h expected none", bus_rdata);
      end else begin
        check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (300000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check({31'b0, intx_irq}, 32'd0, "R1 intx after reset");
    check({31'b0, err_irq},  32'd0, "R1 err after reset");
    check(bus_rdata, 32'd0, "R1 rdata after reset");
    rd(4'h0, 32'h0, "R1 cause reset");
    rd(4'h4, 32'h0, "R1 mask reset");

    // R6 mask read/write
    wr(4'h4, 32'h0F01_0000);
    rd(4'h4, 32'h0F01_0000, "R6 mask readback");

    // R2 R7 R8 events 16, 17, 24
    pulse(32'h0103_0000);
    tick();
    check({31'b0, intx_irq}, 32'd1, "R7 intx on bit24");
    check({31'b0, err_irq},  32'd1, "R8 err on bit16");
    rd(4'h0, 32'h0103_0000, "R2 cause captured");
    rd(4'h0, 32'h0103_0000, "R3 read does not clear");

    // R4 R10 partial clear of bit 16
    wr(4'h0, 32'h0001_0000);
    tick();
    check({31'b0, err_irq},  32'd0, "R10 err drops after clear");
    check({31'b0, intx_irq}, 32'd1, "R10 intx stays");
    rd(4'h0, 32'h0102_0000, "R4 only bit16 cleared");

    // R9 unmask pending bit 17 raises err
    wr(4'h4, 32'h0F03_0000);
    tick();
    check({31'b0, err_irq}, 32'd1, "R9 err after unmask of pending");
    wr(4'h0, 32'h0102_0000);
    tick();
    check({31'b0, err_irq},  32'd0, "R10 err clear");
    check({31'b0, intx_irq}, 32'd0, "R7 intx clear");

    // R9 masked event sets cause but no line
    pulse(32'h0000_0020);
    tick();
    check({31'b0, err_irq}, 32'd0, "R9 masked no err");
    rd(4'h0, 32'h0000_0020, "R9 masked cause set");

    // R5 set wins over same-cycle clear
    evt_pulse = 32'h0000_0020;
    wr(4'h0, 32'h0000_0020);
    evt_pulse = '0;
    rd(4'h0, 32'h0000_0020, "R5 set wins");
    wr(4'h0, 32'h0000_0020);
    rd(4'h0, 32'h0, "R4 clear after collision");

    // R11 unmapped offset
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, 32'h0, "R11 unmapped read");
    rd(4'h4, 32'h0F03_0000, "R11 mask untouched");
    rd(4'h0, 32'h0, "R11 cause untouched");

    // R7 top of INTx group, err must stay low
    pulse(32'h0800_0000);
    tick();
    check({31'b0, intx_irq}, 32'd1, "R7 intx on bit27");
    check({31'b0, err_irq},  32'd0, "R8 err not raised by intx group");

    repeat (3) tick();
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule